// File: doc/BRIEF.md
# Dual-Speed 1-Wire Bus Master

This block is the host side of a single-wire, open-drain serial bus. A host asks for one of three actions through a small command port: a bus reset with presence detection, a byte write, or a byte read. The block then produces the matching low pulses on the line and samples the line at fixed points. It reports completion with a one-cycle `done` pulse, together with the presence flag or the received byte. Bytes travel least significant bit first, eight time slots per byte. Software can build ROM search, ROM ID readout and higher-level device commands on top of these primitives.

Two timing sets are provided, standard and overdrive, and `speed_od` picks one of them for each command. The choice matters for slaves that work only at overdrive speed: such a slave stays silent after a reset pulse of standard length, so the host must issue an overdrive-length reset to find it. Every duration is a cycle count that is computed at elaboration from the `CLK_HZ` parameter, rounded up. The pin itself is handled outside the block. The block gives only a pull-low enable and takes back the synchronized line level.

Top module: `ow_master`

## Requirements
- R1: A reset command holds `bus_pull_low` high for 480 µs in standard speed and 70 µs in overdrive, each as ceil(CLK_HZ·t) cycles with a tolerance of one cycle.
- R2: After the reset pulse is released, the line is sampled once, 70 µs later in standard speed and 8.5 µs later in overdrive. `presence` becomes 1 only if the line is low at that point. A presence pulse that ends before the sample point reads as 0, and so does silence from a slave that answers only overdrive-length resets when a standard reset is sent.
- R3: In a write slot, a 1 bit pulls the line low for 6 µs (standard) or 1 µs (overdrive), and a 0 bit for 60 µs or 7.5 µs, within one cycle.
- R4: Consecutive slots of one byte start at least 70 µs apart in standard speed and 12 µs in overdrive, and at most 4 cycles more. This spacing includes the recovery time.
- R5: A read slot pulls the line low for the write-1 time and samples the line 15 µs (standard) or 2 µs (overdrive) after the falling edge. A high line gives bit 1. `rdata` holds the byte assembled from the eight slots, with the first slot as bit 0.
- R6: A write command `cmd_op`=2 sends `cmd_wdata` bit 0 first and bit 7 last, in exactly eight slots.
- R7: `bus_pull_low` is the only line output. A 1 pulls the line low and a 0 releases it, so the block never drives the line high. While `busy` is 0, `bus_pull_low` is 0.
- R8: Commands are accepted only when `busy` is 0 and `cmd_valid` is 1, with `cmd_op` 1 = reset, 2 = write, 3 = read. Code 0, and any command seen while `busy` is 1, has no effect. Each accepted command ends with `done` high for exactly one cycle, in the cycle where `busy` returns to 0.
- R9: After reset, `busy`, `done`, `presence`, `rdata` and `bus_pull_low` are all 0.
- R10: The speed is sampled when a command is accepted. Changing `speed_od` while a command runs does not change its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock whose frequency is CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| speed_od | input | 1 | 1 = overdrive timing, 0 = standard timing, sampled at command accept |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 1 reset, 2 write byte, 3 read byte, 0 no operation |
| cmd_wdata | input | BYTE_BITS | Byte to write |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | Result of the last reset |
| rdata | output | BYTE_BITS | Result of the last read |
| bus_pull_low | output | 1 | Open-drain enable: 1 pulls the line low |
| bus_in | input | 1 | Level observed on the line |

## Verification
Resets are tried against four slave behaviours: answering in time, answering with a pulse that ends too early, staying silent, and answering only overdrive-length resets. Together these separate a correct sample point and reset width from a wrong one at either speed. Bytes with mixed bit patterns (0xA5, 0x5A) separate LSB-first from MSB-first order and the write-1 width from the write-0 width. Single-bit bytes (0x01, 0x80) expose off-by-one slot counts. A speed change in the middle of a command, a command issued while busy and the zero opcode check that only an accepted command, at its sampled speed, reaches the line.

// File: rtl/ow_pkg.sv
`timescale 1ns/1ps
package ow_pkg;

  localparam int OW_TW = 24;
  typedef logic [OW_TW-1:0] ow_cnt_t;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_RESET = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } ow_op_e;

  typedef struct packed {
    ow_cnt_t rst_low;
    ow_cnt_t pres_samp;
    ow_cnt_t rst_high;
    ow_cnt_t w1_low;
    ow_cnt_t w0_low;
    ow_cnt_t rd_samp;
    ow_cnt_t slot_len;
  } ow_times_t;

  // durations in tenths of a microsecond
  localparam longint STD_RST_LOW = 4800, OD_RST_LOW = 700;
  localparam longint STD_PRES    = 700,  OD_PRES    = 85;
  localparam longint STD_RST_HI  = 4100, OD_RST_HI  = 400;
  localparam longint STD_W1      = 60,   OD_W1      = 10;
  localparam longint STD_W0      = 600,  OD_W0      = 75;
  localparam longint STD_RDS     = 150,  OD_RDS     = 20;
  localparam longint STD_SLOT    = 700,  OD_SLOT    = 120;

  function automatic ow_cnt_t ow_cyc(input longint hz, input longint tenth_us);
    longint c;
    c = (hz * tenth_us + 64'd9_999_999) / 64'd10_000_000;
    if (c < 1) c = 1;
    return ow_cnt_t'(c);
  endfunction

  function automatic ow_times_t ow_make(input longint hz, input bit od);
    ow_times_t t;
    t.rst_low   = ow_cyc(hz, od ? OD_RST_LOW : STD_RST_LOW);
    t.pres_samp = ow_cyc(hz, od ? OD_PRES    : STD_PRES);
    t.rst_high  = ow_cyc(hz, od ? OD_RST_HI  : STD_RST_HI);
    t.w1_low    = ow_cyc(hz, od ? OD_W1      : STD_W1);
    t.w0_low    = ow_cyc(hz, od ? OD_W0      : STD_W0);
    t.rd_samp   = ow_cyc(hz, od ? OD_RDS     : STD_RDS);
    t.slot_len  = ow_cyc(hz, od ? OD_SLOT    : STD_SLOT);
    return t;
  endfunction

endpackage

// File: rtl/ow_sync.sv
`timescale 1ns/1ps
module ow_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= {STAGES{RST_VAL}};
        else        ff_q <= {ff_q[STAGES-2:0], d};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= RST_VAL;
        else        ff_q <= d;
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/ow_timing.sv
`timescale 1ns/1ps
module ow_timing
  import ow_pkg::*;
#(
  parameter longint CLK_HZ = 100_000_000
) (
  input  logic      speed_od,
  output ow_times_t times
);
  localparam ow_times_t T_STD = ow_make(CLK_HZ, 1'b0);
  localparam ow_times_t T_OD  = ow_make(CLK_HZ, 1'b1);

  assign times = speed_od ? T_OD : T_STD;
endmodule

// File: rtl/ow_bit_engine.sv
`timescale 1ns/1ps
module ow_bit_engine
  import ow_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      rst_slot_i,
  input  logic      wbit_i,
  input  ow_times_t times_i,
  input  logic      line_i,
  output logic      pull_low_o,
  output logic      done_o,
  output logic      sample_o
);
  typedef enum logic [1:0] {E_IDLE, E_RST, E_SLOT} e_st_t;

  e_st_t     st_q, st_n;
  ow_cnt_t   cnt_q, cnt_n;
  ow_times_t t_q;
  logic      load_t;
  logic      bit_q, bit_n;
  logic      pull_q, pull_n;
  logic      samp_q, samp_n;
  logic      done_q, done_n;
  ow_cnt_t   low_len;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    bit_n   = bit_q;
    pull_n  = 1'b0;
    samp_n  = samp_q;
    done_n  = 1'b0;
    load_t  = 1'b0;
    low_len = bit_q ? t_q.w1_low : t_q.w0_low;
    unique case (st_q)
      E_IDLE: begin
        if (start_i) begin
          st_n   = rst_slot_i ? E_RST : E_SLOT;
          cnt_n  = '0;
          bit_n  = wbit_i;
          load_t = 1'b1;
          pull_n = 1'b1;
        end
      end
      E_RST: begin
        cnt_n  = cnt_q + 1'b1;
        pull_n = (cnt_n < t_q.rst_low);
        if (cnt_q == t_q.rst_low + t_q.pres_samp) samp_n = !line_i;
        if (cnt_q == t_q.rst_low + t_q.rst_high - 1'b1) begin
          st_n   = E_IDLE;
          pull_n = 1'b0;
          done_n = 1'b1;
        end
      end
      E_SLOT: begin
        cnt_n  = cnt_q + 1'b1;
        pull_n = (cnt_n < low_len);
        if (cnt_q == t_q.rd_samp) samp_n = line_i;
        if (cnt_q == t_q.slot_len - 1'b1) begin
          st_n   = E_IDLE;
          pull_n = 1'b0;
          done_n = 1'b1;
        end
      end
      default: st_n = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      cnt_q  <= '0;
      t_q    <= '0;
      bit_q  <= 1'b0;
      pull_q <= 1'b0;
      samp_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      if (load_t) t_q <= times_i;
      bit_q  <= bit_n;
      pull_q <= pull_n;
      samp_q <= samp_n;
      done_q <= done_n;
    end
  end

  assign pull_low_o = pull_q;
  assign done_o     = done_q;
  assign sample_o   = samp_q;

  assert_low_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> $past(start_i));
  assert_times_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != E_IDLE && $past(st_q != E_IDLE)) |-> $stable(t_q));
  assert_done_in_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == E_IDLE && !pull_q));
endmodule

// File: rtl/ow_master.sv
`timescale 1ns/1ps
module ow_master
  import ow_pkg::*;
#(
  parameter longint CLK_HZ      = 100_000_000,
  parameter int     SYNC_STAGES = 2,
  parameter int     BYTE_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 speed_od,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [BYTE_BITS-1:0] cmd_wdata,
  output logic                 busy,
  output logic                 done,
  output logic                 presence,
  output logic [BYTE_BITS-1:0] rdata,
  output logic                 bus_pull_low,
  input  logic                 bus_in
);
  localparam int BC_W = $clog2(BYTE_BITS + 1);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_BITS - 1);

  typedef enum logic [1:0] {T_IDLE, T_RST, T_BYTE} t_st_t;

  logic rst_n_s, line_s;
  ow_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s));
  ow_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_n_s), .d(bus_in), .q(line_s));

  t_st_t                st_q, st_n;
  logic                 speed_q, speed_n;
  logic                 rd_q, rd_n;
  logic [BYTE_BITS-1:0] sh_q, sh_n;
  logic [BC_W-1:0]      bc_q, bc_n;
  logic                 start_q, start_n;
  logic                 pres_q, pres_n;
  logic [BYTE_BITS-1:0] rdata_q, rdata_n;
  logic                 done_q, done_n;

  ow_op_e    op_in;
  ow_times_t times;
  logic      eng_done, eng_sample;

  assign op_in = ow_op_e'(cmd_op);

  ow_timing #(.CLK_HZ(CLK_HZ)) u_timing (
    .speed_od(speed_q), .times(times));

  ow_bit_engine u_engine (
    .clk(clk), .rst_n(rst_n_s),
    .start_i(start_q),
    .rst_slot_i(st_q == T_RST),
    .wbit_i(rd_q | sh_q[0]),
    .times_i(times),
    .line_i(line_s),
    .pull_low_o(bus_pull_low),
    .done_o(eng_done),
    .sample_o(eng_sample));

  always_comb begin
    st_n    = st_q;
    speed_n = speed_q;
    rd_n    = rd_q;
    sh_n    = sh_q;
    bc_n    = bc_q;
    start_n = 1'b0;
    pres_n  = pres_q;
    rdata_n = rdata_q;
    done_n  = 1'b0;
    unique case (st_q)
      T_IDLE: begin
        if (cmd_valid) begin
          unique case (op_in)
            OP_RESET: begin
              speed_n = speed_od;
              start_n = 1'b1;
              st_n    = T_RST;
            end
            OP_WRITE, OP_READ: begin
              speed_n = speed_od;
              rd_n    = (op_in == OP_READ);
              sh_n    = (op_in == OP_READ) ? '0 : cmd_wdata;
              bc_n    = '0;
              start_n = 1'b1;
              st_n    = T_BYTE;
            end
            default: ;
          endcase
        end
      end
      T_RST: begin
        if (eng_done) begin
          pres_n = eng_sample;
          done_n = 1'b1;
          st_n   = T_IDLE;
        end
      end
      T_BYTE: begin
        if (eng_done) begin
          sh_n = {rd_q & eng_sample, sh_q[BYTE_BITS-1:1]};
          bc_n = bc_q + 1'b1;
          if (bc_q == LAST_BIT) begin
            done_n = 1'b1;
            st_n   = T_IDLE;
            if (rd_q) rdata_n = sh_n;
          end else begin
            start_n = 1'b1;
          end
        end
      end
      default: st_n = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= T_IDLE;
      speed_q <= 1'b0;
      rd_q    <= 1'b0;
      sh_q    <= '0;
      bc_q    <= '0;
      start_q <= 1'b0;
      pres_q  <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      speed_q <= speed_n;
      rd_q    <= rd_n;
      sh_q    <= sh_n;
      bc_q    <= bc_n;
      start_q <= start_n;
      pres_q  <= pres_n;
      rdata_q <= rdata_n;
      done_q  <= done_n;
    end
  end

  assign busy     = (st_q != T_IDLE);
  assign done     = done_q;
  assign presence = pres_q;
  assign rdata    = rdata_q;

  assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> !bus_pull_low);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);
  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> (!busy && $past(busy)));
  assert_bitcnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    bc_q <= BC_W'(BYTE_BITS));
  assert_speed_held_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && $past(busy)) |-> $stable(speed_q));
endmodule

// File: tb/ow_master_test.sv
`timescale 1ns/1ps
module ow_master_test;
  localparam longint HZ  = 10_000_000;   // 10 cycles per microsecond
  localparam int     CPU = 10;

  typedef struct packed {
    logic       od;
    logic [1:0] op;
    logic [7:0] wd;
    logic [7:0] stx;
    logic [1:0] pm;   // 0 silent, 1 answers, 2 overdrive-only, 3 early-ending pulse
    logic       ep;
    logic [7:0] er;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd1, 8'h00, 8'h00, 2'd1, 1'b1, 8'h00},
    '{1'b0, 2'd1, 8'h00, 8'h00, 2'd3, 1'b0, 8'h00},
    '{1'b0, 2'd1, 8'h00, 8'h00, 2'd2, 1'b0, 8'h00},
    '{1'b0, 2'd1, 8'h00, 8'h00, 2'd0, 1'b0, 8'h00},
    '{1'b0, 2'd2, 8'hA5, 8'h00, 2'd0, 1'b0, 8'h00},
    '{1'b0, 2'd3, 8'h00, 8'h3C, 2'd0, 1'b0, 8'h3C},
    '{1'b1, 2'd1, 8'h00, 8'h00, 2'd2, 1'b1, 8'h00},
    '{1'b1, 2'd1, 8'h00, 8'h00, 2'd3, 1'b0, 8'h00},
    '{1'b1, 2'd2, 8'h5A, 8'h00, 2'd0, 1'b0, 8'h00},
    '{1'b1, 2'd2, 8'h01, 8'h00, 2'd0, 1'b0, 8'h00},
    '{1'b1, 2'd3, 8'h00, 8'hC3, 2'd0, 1'b0, 8'hC3},
    '{1'b1, 2'd3, 8'h00, 8'h80, 2'd0, 1'b0, 8'h80}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       speed_od, cmd_valid;
  logic [1:0] cmd_op;
  logic [7:0] cmd_wdata;
  logic       busy, done, presence, bus_pull_low, bus_in;
  logic [7:0] rdata;

  int checks = 0, failures = 0;

  // slave model state
  logic       rec_clr;
  logic [1:0] pmode;
  logic       slave_rd_en;
  logic [7:0] slave_tx;
  longint     cyc = 0, fall_t = 0;
  longint     widths [16];
  longint     falls  [16];
  int         nrec = 0;
  logic [2:0] tx_idx = 3'd0;
  logic       prev_pl = 1'b0;
  int         rd_cnt = 0, pw_cnt = 0, pl_cnt = 0, pl_len = 0;

  always #2 clk = ~clk;

  assign bus_in = !(bus_pull_low | (rd_cnt != 0) | (pl_cnt != 0));

  ow_master #(.CLK_HZ(HZ)) uut (
    .clk(clk), .rst_n(rst_n), .speed_od(speed_od), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .presence(presence), .rdata(rdata), .bus_pull_low(bus_pull_low),
    .bus_in(bus_in));

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    prev_pl <= bus_pull_low;
    if (rd_cnt > 0) rd_cnt <= rd_cnt - 1;
    if (pl_cnt > 0) pl_cnt <= pl_cnt - 1;
    if (pw_cnt > 0) begin
      pw_cnt <= pw_cnt - 1;
      if (pw_cnt == 1) pl_cnt <= pl_len;
    end
    if (rec_clr) begin
      nrec   <= 0;
      tx_idx <= 3'd0;
    end else begin
      if (bus_pull_low && !prev_pl) begin
        fall_t <= cyc;
        if (nrec < 16) falls[nrec] <= cyc;
        if (slave_rd_en) begin
          if (!slave_tx[tx_idx]) rd_cnt <= speed_od ? 40 : 300;
          tx_idx <= tx_idx + 3'd1;
        end
      end
      if (!bus_pull_low && prev_pl) begin
        if (nrec < 16) widths[nrec] <= cyc - fall_t;
        nrec <= nrec + 1;
        if ((cyc - fall_t) > (speed_od ? 400 : 3000) && pmode != 2'd0) begin
          if (pmode != 2'd2 || ((cyc - fall_t) >= 600 && (cyc - fall_t) <= 900)) begin
            pw_cnt <= speed_od ? 20 : 300;
            pl_len <= (pmode == 2'd3) ? (speed_od ? 40 : 200) : (speed_od ? 100 : 1500);
          end
        end
      end
    end
  end

  function automatic longint t_cyc(input longint tenth);
    return tenth * CPU / 10;
  endfunction

  function automatic longint absd(input longint a, input longint b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] wd);
    @(negedge clk) rec_clr = 1'b1;
    @(negedge clk) begin
      rec_clr   = 1'b0;
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_wdata = wd;
    end
    @(negedge clk) cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    check(!busy, "R8", "busy in done cycle", busy, 0);
    @(negedge clk);
    check(!done, "R8", "done width", done, 0);
  endtask

  task automatic check_slots(input bit od, input logic [7:0] bits, input bit is_rd);
    longint w1, w0, sl;
    w1 = t_cyc(od ? 10 : 60);
    w0 = t_cyc(od ? 75 : 600);
    sl = t_cyc(od ? 120 : 700);
    check(nrec == 8, "R6", "slot count", nrec, 8);
    for (int b = 0; b < 8; b++) begin
      longint ew;
      ew = (is_rd || bits[b]) ? w1 : w0;
      if (is_rd) check(absd(widths[b], ew) <= 1, "R5", "read low width", widths[b], ew);
      else begin
        check(absd(widths[b], ew) <= 1, "R3", "write low width", widths[b], ew);
        check((widths[b] < (w1 + w0) / 2) == bits[b], "R6", "bit order", widths[b], ew);
      end
      if (b > 0)
        check(falls[b] - falls[b-1] >= sl && falls[b] - falls[b-1] <= sl + 4,
              "R4", "slot spacing", falls[b] - falls[b-1], sl);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; speed_od = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_wdata = 8'h00;
    rec_clr = 1'b1; pmode = 2'd0; slave_rd_en = 1'b0; slave_tx = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rec_clr = 1'b0;

    // R9: reset state
    check(!busy && !done, "R9", "busy/done after reset", {busy, done}, 0);
    check(!presence, "R9", "presence after reset", presence, 0);
    check(rdata == 8'h00, "R9", "rdata after reset", rdata, 0);
    check(!bus_pull_low, "R9", "line released after reset", bus_pull_low, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      speed_od    = VEC[i].od;
      pmode       = VEC[i].pm;
      slave_tx    = VEC[i].stx;
      slave_rd_en = (VEC[i].op == 2'd3);
      run_cmd(VEC[i].op, VEC[i].wd);
      if (VEC[i].op == 2'd1) begin
        longint er;
        er = t_cyc(VEC[i].od ? 700 : 4800);
        check(nrec == 1, "R1", "reset pulse count", nrec, 1);
        check(absd(widths[0], er) <= 1, "R1", "reset low width", widths[0], er);
        check(presence == VEC[i].ep, "R2", "presence flag", presence, VEC[i].ep);
      end else if (VEC[i].op == 2'd2) begin
        check_slots(VEC[i].od, VEC[i].wd, 1'b0);
      end else begin
        check_slots(VEC[i].od, 8'hFF, 1'b1);
        check(rdata == VEC[i].er, "R5", "read byte", rdata, VEC[i].er);
      end
      check(!bus_pull_low, "R7", "line released when idle", bus_pull_low, 0);
    end
    slave_rd_en = 1'b0;
    pmode = 2'd0;

    // R8: opcode 0 is ignored
    @(negedge clk) begin rec_clr = 1'b1; end
    @(negedge clk) begin rec_clr = 1'b0; cmd_valid = 1'b1; cmd_op = 2'd0; end
    @(negedge clk) cmd_valid = 1'b0;
    begin
      int seen;
      seen = 0;
      repeat (30) begin
        @(negedge clk);
        if (busy || bus_pull_low || done) seen++;
      end
      check(seen == 0, "R8", "no-op activity", seen, 0);
      check(nrec == 0, "R7", "no-op line pulses", nrec, 0);
    end

    // R8: command while busy is ignored
    speed_od = 1'b1;
    @(negedge clk) rec_clr = 1'b1;
    @(negedge clk) begin rec_clr = 1'b0; cmd_valid = 1'b1; cmd_op = 2'd2; cmd_wdata = 8'hFF; end
    @(negedge clk) cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    @(negedge clk) begin cmd_valid = 1'b1; cmd_op = 2'd3; end
    @(negedge clk) cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    repeat (200) @(negedge clk);
    check(!busy, "R8", "busy after ignored command", busy, 0);
    check(nrec == 8, "R8", "slots after ignored command", nrec, 8);
    check(absd(widths[7], t_cyc(10)) <= 1, "R8", "write-1 kept", widths[7], t_cyc(10));

    // R10: speed flip during a standard write
    speed_od = 1'b0;
    @(negedge clk) rec_clr = 1'b1;
    @(negedge clk) begin rec_clr = 1'b0; cmd_valid = 1'b1; cmd_op = 2'd2; cmd_wdata = 8'h00; end
    @(negedge clk) begin cmd_valid = 1'b0; speed_od = 1'b1; end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(nrec == 8, "R10", "slot count after speed flip", nrec, 8);
    for (int b = 0; b < 8; b++)
      check(absd(widths[b], t_cyc(600)) <= 1, "R10", "standard write-0 kept",
            widths[b], t_cyc(600));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule